// File: doc/BRIEF.md
# CAN Receive Bit Sampler with Edge Resynchronization

This block turns an oversampled CAN receive line into a stream of bit values. It runs on the system clock. The caller gives a bit length in clock cycles and a sample offset in clock cycles. While the bus is free, the block watches for the line to go dominant (low). That cycle marks the start of a frame and the time reference for bit 0. From then on it emits one strobe per bit, together with the sampled level and the bit's position in the frame.

A sample point is never taken from a free-running bit timer. The block measures it from the latest time reference, which is either the frame start or the most recent recessive-to-dominant transition on the line. The sample falls a whole number of bit lengths after that reference, plus the offset. This lets the receiver follow a transmitter whose rate differs a little from nominal.

The block does not parse frames, so stuff bits are sampled and counted like any other bit. A downstream parser tells the block when the frame is over, and the block then returns to waiting for the next start.

Top module: `can_bit_sampler`

## Requirements
- R1: During reset and after it, `bit_valid` is 0, `bit_idx` is 0, the block waits for a frame start, and the synchronizer stages hold the recessive level 1.
- R2: While waiting for a frame start, no strobe is produced as long as the synchronized line is 1. The first cycle in which the synchronized line is 0 starts the frame and becomes the time reference for bit 0.
- R3: With time reference cycle A and reference bit index a, the sample for bit k is taken in cycle A + L·(k − a) + O. Here L is the effective bit length and O is the effective offset. `bit_valid` is 1 during the cycle after the sample cycle.
- R4: With a strobe, `bit_value` gives the synchronized line level in the sample cycle. `bit_idx` gives the bit's position: 0 for the first sample after a frame start, then 1 higher for every later sample, stuff bits included, wrapping at the width of `bit_idx`.
- R5: During a frame, every cycle in which the synchronized line goes from 1 to 0 becomes the new time reference. Its reference bit index is the index of the next bit not yet sampled. A sample that R3 would place in that same cycle or later is replaced by the new schedule.
- R6: An offset of 0 samples in the reference cycle itself. An offset of L or more acts as L − 1.
- R7: A `bit_len` below 4 acts as 4.
- R8: When `frame_end` is 1 in a cycle, no sample is taken in that cycle. In the next cycle the block waits for a new frame start, `bit_idx` is 0, and the bit counter is cleared.
- R9: `bit_valid` is high for one cycle at a time and is never high in two consecutive cycles. A sample is skipped if it would fall in the cycle right after another sample.
- R10: `rx_async` passes through two flip-flops before any edge detection or sampling. A line change at one clock edge reaches the sampling logic in the cycle after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_async | input | 1 | CAN receive line, not yet synchronized (0 = dominant) |
| bit_len | input | CNT_W | Bit length in clock cycles |
| samp_ofs | input | CNT_W | Sample offset in clock cycles from the time reference |
| frame_end | input | 1 | End of frame from the downstream parser; returns the block to waiting |
| bit_valid | output | 1 | One-cycle strobe for a sampled bit |
| bit_value | output | 1 | Sampled line level |
| bit_idx | output | IDX_W | Position of the sampled bit in the frame, stuff bits included |

## Verification
Assertions check the following on every cycle:
- the strobe is one cycle wide and strobes are never adjacent;
- the block stays silent while it is waiting and the line is recessive;
- `frame_end` returns the block to waiting with a cleared index;
- the first strobe after a start has index 0;
- falling-edge pulses never repeat;
- the synchronizer has a latency of two cycles.

The sampling schedule itself can only be shown by the bench scenarios. The bench compares the exact strobe cycles, values and indices against an independent model of the reference-plus-whole-periods rule. The model covers a transmitter at the nominal rate, one that is too slow and one that is too fast. It also covers offset clamping, a zero offset, the minimum bit length, and a frame cut short by `frame_end`.

// File: rtl/can_bs_pkg.sv
package can_bs_pkg;

   typedef enum logic {
      BS_WAIT  = 1'b0,
      BS_FRAME = 1'b1
   } bs_state_e;

endpackage

// File: rtl/can_bs_sync.sv
module can_bs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("can_bs_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[0] <= RST_VAL;
               else        chain_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[s] <= RST_VAL;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];

   // cycles since reset release, saturating, so $past never reaches into reset
   logic [1:0] age_q;
   always_ff @(posedge clk) begin
      if (!rst_n)            age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   generate
      if (STAGES == 2) begin : g_chk2
         // R10: line change reaches the output two edges later
         p_sync_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q >= 2'd2) |-> (sync_o == $past(async_i, 2)));
      end
   endgenerate

endmodule

// File: rtl/can_bs_edge.sv
module can_bs_edge #(
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic fall_o
);

   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= IDLE_LVL;
      else        prev_q <= line_i;
   end

   assign fall_o = prev_q & ~line_i;

   // R5: a falling edge is a single-cycle event
   p_fall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);

endmodule

// File: rtl/can_bs_phase.sv
module can_bs_phase #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             anchor_i,
   input  logic [CNT_W-1:0] len_i,
   input  logic [CNT_W-1:0] ofs_i,
   output logic             hit_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] ph_q;
   logic [CNT_W-1:0] ph_now;
   logic [CNT_W-1:0] ph_d;
   logic             hit_q;

   // a new reference restarts the phase at zero in this very cycle
   assign ph_now = anchor_i ? '0 : ph_q;
   assign hit_o  = run_i & (ph_now == ofs_i) & ~hit_q;

   always_comb begin
      if (!run_i)                     ph_d = '0;
      else if (ph_now >= len_i - ONE) ph_d = '0;
      else                            ph_d = ph_now + ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= '0;
         hit_q <= 1'b0;
      end else begin
         ph_q  <= ph_d;
         hit_q <= hit_o;
      end
   end

   // R9: samples are never in adjacent cycles
   p_hit_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> !hit_o);

endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler
   import can_bs_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int IDX_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_LEN     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_async,
   input  logic [CNT_W-1:0] bit_len,
   input  logic [CNT_W-1:0] samp_ofs,
   input  logic             frame_end,
   output logic             bit_valid,
   output logic             bit_value,
   output logic [IDX_W-1:0] bit_idx
);

   localparam logic [CNT_W-1:0] MIN_L   = CNT_W'(MIN_LEN);
   localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);
   localparam logic [IDX_W-1:0] ONE_IDX = IDX_W'(1);

   generate
      if (MIN_LEN < 2 || CNT_W < 3 || CNT_W > 31) begin : g_bad_len
         $error("can_bit_sampler: MIN_LEN or CNT_W out of range");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("can_bit_sampler: IDX_W must be positive");
      end
   endgenerate

   logic             rx_s;
   logic             fall;
   logic             hit;
   logic             start;
   logic             anchor;
   logic             run;
   logic [CNT_W-1:0] len_eff;
   logic [CNT_W-1:0] ofs_eff;
   bs_state_e        state_q;
   logic [IDX_W-1:0] idx_q;

   can_bs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (rx_async),
      .sync_o  (rx_s)
   );

   can_bs_edge #(.IDLE_LVL(1'b1)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (rx_s),
      .fall_o (fall)
   );

   // timing inputs clamped to legal values
   assign len_eff = (bit_len < MIN_L) ? MIN_L : bit_len;
   assign ofs_eff = (samp_ofs >= len_eff) ? (len_eff - ONE_C) : samp_ofs;

   assign start  = (state_q == BS_WAIT) & ~rx_s;
   assign anchor = start | ((state_q == BS_FRAME) & fall);
   assign run    = ~frame_end & ((state_q == BS_FRAME) | start);

   can_bs_phase #(.CNT_W(CNT_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run),
      .anchor_i (anchor),
      .len_i    (len_eff),
      .ofs_i    (ofs_eff),
      .hit_o    (hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= BS_WAIT;
         idx_q   <= '0;
      end else if (frame_end) begin
         state_q <= BS_WAIT;
         idx_q   <= '0;
      end else begin
         if (start) state_q <= BS_FRAME;
         if (hit)   idx_q   <= idx_q + ONE_IDX;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_valid <= 1'b0;
         bit_value <= 1'b1;
         bit_idx   <= '0;
      end else begin
         bit_valid <= hit;
         if (hit) begin
            bit_value <= rx_s;
            bit_idx   <= idx_q;
         end else if (frame_end) begin
            bit_idx   <= '0;
         end
      end
   end

   // R8: end of frame empties the block
   p_end_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (!bit_valid && bit_idx == '0 && state_q == BS_WAIT && idx_q == '0));

   // R2: no strobe while waiting on a recessive line
   p_wait_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == BS_WAIT && rx_s) |=> !bit_valid);

   // R9: strobe is one cycle wide
   p_strobe_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |=> !bit_valid);

   // R4: a strobe right after waiting carries index 0
   p_first_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && $past(state_q == BS_WAIT)) |-> (bit_idx == '0));

endmodule

// File: tb/can_bit_sampler_test.sv
module can_bit_sampler_test;

   localparam int CNT_W = 16;
   localparam int IDX_W = 8;

   logic             clk;
   logic             rst_n;
   logic             rx_async;
   logic [CNT_W-1:0] bit_len;
   logic [CNT_W-1:0] samp_ofs;
   logic             frame_end;
   logic             bit_valid;
   logic             bit_value;
   logic [IDX_W-1:0] bit_idx;

   can_bit_sampler #(.CNT_W(CNT_W), .IDX_W(IDX_W)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_async  (rx_async),
      .bit_len   (bit_len),
      .samp_ofs  (samp_ofs),
      .frame_end (frame_end),
      .bit_valid (bit_valid),
      .bit_value (bit_value),
      .bit_idx   (bit_idx)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // strobe log
   int   lg_t [64];
   logic lg_v [64];
   int   lg_i [64];
   int   n_log = 0;
   bit   prev_valid = 1'b0;
   int   adjacent = 0;

   always @(negedge clk) begin
      if (bit_valid) begin
         if (prev_valid) adjacent++;
         if (n_log < 64) begin
            lg_t[n_log] = cyc;
            lg_v[n_log] = bit_value;
            lg_i[n_log] = int'(bit_idx);
         end
         n_log++;
      end
      prev_valid = bit_valid;
   end

   logic fb [32];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic set_bits(input logic [31:0] pat, input int nb);
      for (int j = 0; j < nb; j++) fb[j] = pat[nb-1-j];
   endtask

   // drive a bit pattern at period q, end it with frame_end, compare with model
   task automatic run_frame(input string nm, input int nb, input int q,
                            input int pin, input int oin, input int tail);
      int c0, e, p, o, nf, prv, a_t, a_k, fi, k, ne, ts, j, ev;
      int fall_t [32];
      @(negedge clk);
      bit_len  = CNT_W'(pin);
      samp_ofs = CNT_W'(oin);
      repeat (3) @(negedge clk);
      n_log = 0;
      c0 = cyc;
      for (int b = 0; b < nb; b++) begin
         rx_async = fb[b];
         repeat (q) @(negedge clk);
      end
      rx_async = 1'b1;
      repeat (tail) @(negedge clk);
      e = cyc;
      frame_end = 1'b1;
      @(negedge clk);
      frame_end = 1'b0;
      // R8: index cleared right after end of frame
      chk(bit_idx == '0 && !bit_valid, "R8", {nm, " cleared after end"}, int'(bit_idx), 0);
      repeat (3) @(negedge clk);
      // model
      p = (pin < 4) ? 4 : pin;
      o = (oin >= p) ? p - 1 : oin;
      nf = 0; prv = 1;
      for (int b = 0; b < nb; b++) begin
         if (fb[b] == 1'b0 && prv == 1) begin
            fall_t[nf] = c0 + q * b + 3;
            nf++;
         end
         prv = int'(fb[b]);
      end
      a_t = fall_t[0]; a_k = 0; fi = 1; k = 0; ne = 0;
      while (ne < 64) begin
         ts = a_t + p * (k - a_k) + o;
         if (fi < nf && fall_t[fi] <= ts) begin
            a_t = fall_t[fi]; a_k = k; fi++;
         end else if (ts <= e) begin
            j  = (ts - 3 - c0) / q;
            ev = (j >= nb) ? 1 : int'(fb[j]);
            if (ne < n_log) begin
               chk(lg_t[ne] == ts, "R3 R5 R10", {nm, " strobe cycle"}, lg_t[ne] - c0, ts - c0);
               chk(int'(lg_v[ne]) == ev, "R4", {nm, " bit value"}, int'(lg_v[ne]), ev);
               chk(lg_i[ne] == (k % 256), "R4", {nm, " bit index"}, lg_i[ne], k % 256);
            end
            ne++; k++;
         end else break;
      end
      chk(n_log == ne, "R3 R8", {nm, " strobe count"}, n_log, ne);
   endtask

   task automatic t_reset;
      rst_n = 1'b0; rx_async = 1'b1; frame_end = 1'b0;
      bit_len = CNT_W'(10); samp_ofs = CNT_W'(7);
      repeat (5) @(negedge clk);
      chk(!bit_valid && bit_idx == '0, "R1", "during reset", int'(bit_valid), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!bit_valid && bit_idx == '0, "R1", "after reset", int'(bit_idx), 0);
   endtask

   task automatic t_idle;
      n_log = 0;
      repeat (40) @(negedge clk);
      chk(n_log == 0, "R2", "idle recessive no strobe", n_log, 0);
   endtask

   task automatic t_nominal;
      set_bits(32'h0000_63A4, 16);
      run_frame("nominal", 16, 10, 10, 7, 25);
   endtask

   task automatic t_slow;
      set_bits(32'h0000_7A16, 16);
      run_frame("slow sender R5", 16, 11, 10, 7, 25);
   endtask

   task automatic t_fast;
      set_bits(32'h0000_3C5B, 16);
      run_frame("fast sender R5", 16, 9, 10, 5, 20);
   endtask

   task automatic t_ofs_clamp;
      set_bits(32'h0000_0D31, 14);
      run_frame("offset clamp R6", 14, 8, 8, 20, 12);
   endtask

   task automatic t_ofs_zero;
      set_bits(32'h0000_00B5, 10);
      run_frame("offset zero R6", 10, 6, 6, 0, 12);
   endtask

   task automatic t_short_len;
      set_bits(32'h0000_0269, 12);
      run_frame("short len R7", 12, 4, 2, 2, 10);
   endtask

   task automatic t_early_end;
      set_bits(32'h0000_1840, 14);
      run_frame("early end R8", 14, 10, 10, 4, 2);
      n_log = 0;
      repeat (30) @(negedge clk);
      chk(n_log == 0, "R8", "quiet after end", n_log, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_idle();
      t_nominal();
      t_slow();
      t_fast();
      t_ofs_clamp();
      t_ofs_zero();
      t_short_len();
      t_early_end();
      chk(adjacent == 0, "R9", "adjacent strobes", adjacent, 0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule